// File: doc/BRIEF.md
# Partitioned Four-Way LRU Replacement Controller

This block manages way replacement for a small four-way set-associative read cache that serves both instruction fetches and data reads. For every set it holds a valid bit per way and a full recency order of the four ways. On each allocating miss it names the victim way and the set, so that the tag and data arrays can load the line there. It also turns per-way invalidate strobes and a buffer-flush strobe into clear pulses for the arrays and buffers around it.

A 3-bit mode input decides which ways each access type may allocate into. All four ways can be shared by both access types. Alternatively, one of two fixed splits reserves some ways for instruction fetches and the rest for data. Per-way lock bits keep ways out of victim selection. Separate enables stop instruction or data misses from allocating.

Top module: `way_repl_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge after that, `way_clr_o` is 4'b1111, `buf_clr_o` is 1 and `fill_o` is 0. Reset leaves every way of every set invalid, and each set's recency order with way 0 least recent and way 3 most recent.
- R2: In mode 3'b000 the four ways form one partition shared by both access types. When all of them are valid and unlocked, the victim is the least recently used way. A hit and a fill each make the touched way the most recent.
- R3: In mode 3'b010, instruction misses (`acc_instr_i`=1) allocate only into ways 0 and 1, and data misses only into ways 2 and 3. Each pair follows its own recency order.
- R4: In mode 3'b011, instruction misses allocate only into ways 0, 1 and 2, and data misses only into way 3.
- R5: The reserved mode values 3'b001 and 3'b1xx select the same allocation as mode 3'b000.
- R6: Within the allowed, unlocked ways, an invalid way is chosen before any valid one, and the lowest-numbered invalid way wins.
- R7: A way whose `lock_i` bit is 1 is never chosen as a victim. A miss whose allowed ways are all locked produces no fill.
- R8: Setting bit n of `inv_i` for one cycle makes `way_clr_o` equal `inv_i` in the next cycle and leaves way n invalid in every set. A 0 bit leaves its way unchanged.
- R9: Invalidation clears a way even while its lock bit is set.
- R10: With `icache_en_i`=0 an instruction miss produces no fill and leaves the valid and recency state unchanged. `dcache_en_i`=0 does the same for data misses.
- R11: A one-cycle `buf_inv_i` strobe gives a one-cycle `buf_clr_o` pulse in the next cycle, keeps `way_clr_o` at 0, and does not change any way's state.
- R12: Any change of `mode_i`, including a change between reserved values, returns the recency order of every set to way 0 least recent through way 3 most recent.
- R13: `fill_o`, `fill_way_o` and `fill_set_o` show the result of an access one clock edge after that access. A hit never produces a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Partition mode |
| icache_en_i | input | 1 | Instruction misses may allocate |
| dcache_en_i | input | 1 | Data misses may allocate |
| lock_i | input | 4 | Per-way lock, 1 = excluded from victim choice |
| inv_i | input | 4 | Per-way invalidate strobe |
| buf_inv_i | input | 1 | Buffer flush strobe |
| acc_vld_i | input | 1 | Access valid this cycle |
| acc_instr_i | input | 1 | 1 = instruction fetch, 0 = data read |
| acc_set_i | input | SET_W | Set index of the access |
| acc_hit_i | input | 1 | Access hit in the cache |
| acc_hit_way_i | input | 2 | Way that hit |
| fill_o | output | 1 | Allocation happens |
| fill_way_o | output | 2 | Victim way |
| fill_set_o | output | SET_W | Set of the allocation |
| way_clr_o | output | 4 | Per-way clear pulse to the arrays |
| buf_clr_o | output | 1 | Clear pulse to the prefetch and page buffers |

## Verification
The hardest case to reach is a fully valid set whose recency order has been shaped by a specific history of hits, fills, mode changes and invalidations. In that state, only the victim reveals whether a partition, lock or reset rule was applied correctly. The stimulus fills one set through every way first. It then interleaves hits, locks and mode switches on that set, and lets a bench-side recency model predict each later victim. A locked way that is invalidated, unlocked and then chosen first shows that the clear overrode the lock.

// File: rtl/wrc_pkg.sv
// Package: shared types and helpers for the way replacement controller.
// Assumes exactly four ways; ranks are 0 (least recent) .. 3 (most recent).
package wrc_pkg;
    localparam int WAYS  = 4;
    localparam int WAY_W = 2;

    typedef logic [WAY_W-1:0]             way_idx_t;
    typedef logic [WAYS-1:0]              way_vec_t;
    typedef logic [WAYS-1:0][WAY_W-1:0]   rank_vec_t;

    typedef enum logic [2:0] {
        MODE_SHARED   = 3'b000,
        MODE_SPLIT_22 = 3'b010,
        MODE_SPLIT_31 = 3'b011
    } repl_mode_e;

    // Recency order after reset or a mode change: way n holds rank n.
    function automatic rank_vec_t home_order();
        rank_vec_t r;
        for (int w = 0; w < WAYS; w++) begin
            r[w] = way_idx_t'(w);
        end
        return r;
    endfunction

    // Make way t most recent; ways that were more recent shift down by one.
    function automatic rank_vec_t touch_rank(rank_vec_t r, way_idx_t t);
        rank_vec_t n;
        n = r;
        for (int j = 0; j < WAYS; j++) begin
            if (way_idx_t'(j) == t) begin
                n[j] = way_idx_t'(WAYS - 1);
            end else if (r[j] > r[t]) begin
                n[j] = r[j] - 1'b1;
            end
        end
        return n;
    endfunction
endpackage

// File: rtl/wrc_partition.sv
// Module: wrc_partition
// Maps the mode and access type to the set of ways that may allocate.
// Assumes reserved modes fall back to the shared four-way partition.
module wrc_partition
    import wrc_pkg::*;
(
    input  logic [2:0] mode_i,
    input  logic       instr_i,
    output way_vec_t   allowed_o
);
    // Decode the partition mask for this access type.
    always_comb begin
        unique case (mode_i)
            MODE_SPLIT_22: allowed_o = instr_i ? 4'b0011 : 4'b1100;
            MODE_SPLIT_31: allowed_o = instr_i ? 4'b0111 : 4'b1000;
            default:       allowed_o = 4'b1111;
        endcase
    end
endmodule

// File: rtl/wrc_victim.sv
// Module: wrc_victim
// Chooses a victim among allowed, unlocked ways: the lowest invalid way
// first, otherwise the way with the lowest rank. Assumes the ranks are unique.
module wrc_victim
    import wrc_pkg::*;
(
    input  way_vec_t  allowed_i,
    input  way_vec_t  lock_i,
    input  way_vec_t  valid_i,
    input  rank_vec_t rank_i,
    output logic      found_o,
    output way_idx_t  way_o
);
    way_vec_t         cand;
    logic             have_inv;
    way_idx_t         inv_way;
    way_idx_t         lru_way;
    logic [WAY_W:0]   best;

    // Candidate ways: inside the partition and not locked.
    always_comb begin
        cand    = allowed_i & ~lock_i;
        found_o = |cand;
    end

    // Lowest-numbered invalid candidate.
    always_comb begin
        have_inv = 1'b0;
        inv_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (cand[w] && !valid_i[w]) begin
                have_inv = 1'b1;
                inv_way  = way_idx_t'(w);
            end
        end
    end

    // Least recently used candidate.
    always_comb begin
        best    = (WAY_W + 1)'(WAYS);
        lru_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (cand[w] && ({1'b0, rank_i[w]} < best)) begin
                best    = {1'b0, rank_i[w]};
                lru_way = way_idx_t'(w);
            end
        end
    end

    // Invalid ways win over recency.
    always_comb begin
        way_o = have_inv ? inv_way : lru_way;
    end
endmodule

// File: rtl/wrc_set_state.sv
// Module: wrc_set_state
// Holds the valid bits and recency ranks of every set. Invalidation clears
// a way in all sets and beats a fill of the same way in the same cycle;
// an order reset beats a touch.
module wrc_set_state
    import wrc_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set_i,
    input  logic             touch_en_i,
    input  way_idx_t         touch_way_i,
    input  logic             fill_en_i,
    input  way_vec_t         inv_mask_i,
    input  logic             order_reset_i,
    output way_vec_t         rd_valid_o,
    output rank_vec_t        rd_rank_o
);
    way_vec_t  valid_all [NUM_SETS];
    rank_vec_t rank_all  [NUM_SETS];
    way_vec_t  fill_mask;

    // One-hot mask of the way being filled.
    always_comb begin
        fill_mask = fill_en_i ? way_vec_t'(1 << touch_way_i) : '0;
    end

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        way_vec_t  valid_q;
        rank_vec_t rank_q;
        logic      sel;

        assign sel = (rd_set_i == SET_W'(s));

        // Per-set valid and recency update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= '0;
                rank_q  <= home_order();
            end else begin
                valid_q <= (valid_q | (sel ? fill_mask : '0)) & ~inv_mask_i;
                if (order_reset_i) begin
                    rank_q <= home_order();
                end else if (touch_en_i && sel) begin
                    rank_q <= touch_rank(rank_q, touch_way_i);
                end
            end
        end

        assign valid_all[s] = valid_q;
        assign rank_all[s]  = rank_q;
    end

    // Read port for the set of the current access.
    always_comb begin
        rd_valid_o = valid_all[rd_set_i];
        rd_rank_o  = rank_all[rd_set_i];
    end
endmodule

// File: rtl/way_repl_ctrl.sv
// Module: way_repl_ctrl
// Replacement and way management for a four-way read cache shared by
// instruction fetches and data reads. Accesses are taken one per cycle;
// results appear one edge later. Assumes acc_hit_way_i names a valid way.
module way_repl_ctrl
    import wrc_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic             icache_en_i,
    input  logic             dcache_en_i,
    input  logic [3:0]       lock_i,
    input  logic [3:0]       inv_i,
    input  logic             buf_inv_i,
    input  logic             acc_vld_i,
    input  logic             acc_instr_i,
    input  logic [SET_W-1:0] acc_set_i,
    input  logic             acc_hit_i,
    input  logic [1:0]       acc_hit_way_i,
    output logic             fill_o,
    output logic [1:0]       fill_way_o,
    output logic [SET_W-1:0] fill_set_o,
    output logic [3:0]       way_clr_o,
    output logic             buf_clr_o
);
    logic [2:0]       mode_q;
    logic             mode_chg;
    way_vec_t         allowed;
    way_vec_t         set_valid;
    rank_vec_t        set_rank;
    logic             vict_found;
    way_idx_t         vict_way;
    logic             alloc_en;
    logic             do_fill;
    logic             do_touch;
    way_idx_t         touch_way;
    logic             fill_q;
    way_idx_t         fill_way_q;
    logic [SET_W-1:0] fill_set_q;
    logic [3:0]       way_clr_q;
    logic             buf_clr_q;

    wrc_partition i_part (
        .mode_i    (mode_i),
        .instr_i   (acc_instr_i),
        .allowed_o (allowed)
    );

    wrc_set_state #(.NUM_SETS(NUM_SETS)) i_state (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_set_i      (acc_set_i),
        .touch_en_i    (do_touch),
        .touch_way_i   (touch_way),
        .fill_en_i     (do_fill),
        .inv_mask_i    (inv_i),
        .order_reset_i (mode_chg),
        .rd_valid_o    (set_valid),
        .rd_rank_o     (set_rank)
    );

    wrc_victim i_vict (
        .allowed_i (allowed),
        .lock_i    (lock_i),
        .valid_i   (set_valid),
        .rank_i    (set_rank),
        .found_o   (vict_found),
        .way_o     (vict_way)
    );

    // Remember the last mode to detect any change of the field.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_SHARED;
        else        mode_q <= mode_i;
    end

    // Decide whether this access allocates and which way it touches.
    always_comb begin
        mode_chg  = (mode_i != mode_q);
        alloc_en  = acc_instr_i ? icache_en_i : dcache_en_i;
        do_fill   = acc_vld_i && !acc_hit_i && alloc_en && vict_found;
        do_touch  = (acc_vld_i && acc_hit_i) || do_fill;
        touch_way = acc_hit_i ? acc_hit_way_i : vict_way;
    end

    // Register the fill result for the arrays.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q     <= 1'b0;
            fill_way_q <= '0;
            fill_set_q <= '0;
        end else begin
            fill_q     <= do_fill;
            fill_way_q <= vict_way;
            fill_set_q <= acc_set_i;
        end
    end

    // Clear pulses; held fully on during reset so the arrays are wiped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            way_clr_q <= 4'b1111;
            buf_clr_q <= 1'b1;
        end else begin
            way_clr_q <= inv_i;
            buf_clr_q <= buf_inv_i;
        end
    end

    assign fill_o     = fill_q;
    assign fill_way_o = fill_way_q;
    assign fill_set_o = fill_set_q;
    assign way_clr_o  = way_clr_q;
    assign buf_clr_o  = buf_clr_q;
endmodule

// File: rtl/way_repl_ctrl_chk.sv
// Module: way_repl_ctrl_chk
// Temporal checks on the port behaviour of way_repl_ctrl, bound to it below.
module way_repl_ctrl_chk #(
    parameter int SET_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode_i,
    input logic             icache_en_i,
    input logic             dcache_en_i,
    input logic [3:0]       lock_i,
    input logic             acc_vld_i,
    input logic             acc_instr_i,
    input logic             acc_hit_i,
    input logic             fill_o,
    input logic [1:0]       fill_way_o
);
    // R7
    fill_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o |-> ((($past(lock_i) >> fill_way_o) & 4'd1) == 4'd0));

    // R3
    split22_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_o && $past(mode_i) == 3'b010 && $past(acc_instr_i)) |-> !fill_way_o[1]);

    // R3
    split22_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_o && $past(mode_i) == 3'b010 && !$past(acc_instr_i)) |-> fill_way_o[1]);

    // R4
    split31_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_o && $past(mode_i) == 3'b011 && !$past(acc_instr_i)) |-> fill_way_o == 2'd3);

    // R10
    idis_noalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld_i && !acc_hit_i && acc_instr_i && !icache_en_i) |=> !fill_o);

    // R10
    ddis_noalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld_i && !acc_hit_i && !acc_instr_i && !dcache_en_i) |=> !fill_o);

    // R13
    hit_nofill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld_i && acc_hit_i) |=> !fill_o);
endmodule

bind way_repl_ctrl way_repl_ctrl_chk #(.SET_W(SET_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .icache_en_i (icache_en_i),
    .dcache_en_i (dcache_en_i),
    .lock_i      (lock_i),
    .acc_vld_i   (acc_vld_i),
    .acc_instr_i (acc_instr_i),
    .acc_hit_i   (acc_hit_i),
    .fill_o      (fill_o),
    .fill_way_o  (fill_way_o)
);

// File: tb/test_way_repl_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts each access result from a
// recency model and queues it; the monitor compares after each edge.
module test_way_repl_ctrl;
    localparam int SETS = 16;
    localparam int SW   = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    mode_i;
    logic          icache_en_i, dcache_en_i;
    logic [3:0]    lock_i, inv_i;
    logic          buf_inv_i;
    logic          acc_vld_i, acc_instr_i, acc_hit_i;
    logic [SW-1:0] acc_set_i;
    logic [1:0]    acc_hit_way_i;
    logic          fill_o;
    logic [1:0]    fill_way_o;
    logic [SW-1:0] fill_set_o;
    logic [3:0]    way_clr_o;
    logic          buf_clr_o;

    always #2.5 clk = ~clk;

    way_repl_ctrl #(.NUM_SETS(SETS)) i_way_repl_ctrl (.*);

    typedef struct {
        bit    fill;
        int    way;
        int    set;
        string req;
    } exp_t;

    exp_t  exp_q[$];
    int    m_rank [SETS][4];
    bit    m_valid[SETS][4];
    int    mode_cur;
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void model_home();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < 4; w++) m_rank[s][w] = w;
    endfunction

    function automatic void model_touch(int s, int t);
        int old;
        old = m_rank[s][t];
        for (int w = 0; w < 4; w++)
            if (w == t) m_rank[s][w] = 3;
            else if (m_rank[s][w] > old) m_rank[s][w]--;
    endfunction

    // Driver: predict, queue, then present the access for one cycle.
    task automatic access(bit instr, int s, bit hit, int hway, string req);
        exp_t e;
        bit   allow[4];
        int   eff, v, best;
        bit   en, found;
        eff = (mode_cur == 2 || mode_cur == 3) ? mode_cur : 0;
        for (int w = 0; w < 4; w++) begin
            if (eff == 2)      allow[w] = instr ? (w < 2) : (w >= 2);
            else if (eff == 3) allow[w] = instr ? (w < 3) : (w == 3);
            else               allow[w] = 1'b1;
            if (lock_i[w]) allow[w] = 1'b0;
        end
        en = instr ? icache_en_i : dcache_en_i;
        e.fill = 1'b0; e.way = 0; e.set = s; e.req = req;
        if (hit) begin
            model_touch(s, hway);
        end else if (en) begin
            found = 1'b0; v = 0; best = 9;
            for (int w = 0; w < 4; w++)
                if (allow[w] && !m_valid[s][w] && !found) begin found = 1'b1; v = w; end
            if (!found)
                for (int w = 0; w < 4; w++)
                    if (allow[w] && m_rank[s][w] < best) begin best = m_rank[s][w]; v = w; found = 1'b1; end
            if (found) begin
                e.fill = 1'b1; e.way = v;
                m_valid[s][v] = 1'b1;
                model_touch(s, v);
            end
        end
        exp_q.push_back(e);
        @(negedge clk);
        acc_vld_i = 1'b1; acc_instr_i = instr; acc_set_i = SW'(s);
        acc_hit_i = hit;  acc_hit_way_i = 2'(hway);
        @(negedge clk);
        acc_vld_i = 1'b0; acc_hit_i = 1'b0;
    endtask

    task automatic set_mode(int m);
        if (m != mode_cur) model_home();
        mode_cur = m;
        @(negedge clk); mode_i = 3'(m);
        @(negedge clk);
    endtask

    task automatic inval(logic [3:0] m, string req);
        @(negedge clk); inv_i = m;
        @(posedge clk); #1;
        chk(way_clr_o == m, req, "way_clr_o", way_clr_o, m);
        @(negedge clk); inv_i = 4'b0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < 4; w++) if (m[w]) m_valid[s][w] = 1'b0;
    endtask

    // Monitor: compare each access result one edge after the access.
    always @(posedge clk) begin : mon
        bit   was;
        exp_t e;
        was = acc_vld_i && rst_n;
        #1;
        if (was) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R13", "queue empty", 0, 1);
            end else begin
                e = exp_q.pop_front();
                chk(fill_o == e.fill, e.req, "fill_o", fill_o, e.fill);
                if (e.fill && fill_o) begin
                    chk(fill_way_o == 2'(e.way), e.req, "fill_way_o", fill_way_o, e.way);
                    chk(fill_set_o == SW'(e.set), "R13", "fill_set_o", fill_set_o, e.set);
                end
            end
        end else if (rst_n && fill_o) begin
            chk(1'b0, "R13", "spurious fill_o", 1, 0);
        end
    end

    initial begin : wdog
        #(200000 * 5);
        if (!done) begin
            chk(1'b0, "WDOG", "watchdog expired", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        rst_n = 1'b0; mode_i = 3'b000; mode_cur = 0;
        icache_en_i = 1'b1; dcache_en_i = 1'b1;
        lock_i = 4'b0; inv_i = 4'b0; buf_inv_i = 1'b0;
        acc_vld_i = 1'b0; acc_instr_i = 1'b0; acc_set_i = '0;
        acc_hit_i = 1'b0; acc_hit_way_i = 2'b0;
        model_home();
        for (int s = 0; s < SETS; s++) for (int w = 0; w < 4; w++) m_valid[s][w] = 1'b0;
        repeat (3) @(negedge clk);
        chk(way_clr_o == 4'hF, "R1", "way_clr_o in reset", way_clr_o, 15);
        chk(buf_clr_o == 1'b1, "R1", "buf_clr_o in reset", buf_clr_o, 1);
        chk(fill_o == 1'b0,    "R1", "fill_o in reset", fill_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(way_clr_o == 4'h0, "R1", "way_clr_o after reset", way_clr_o, 0);

        // R6: empty set fills lowest invalid way first
        for (int i = 0; i < 4; i++) access(1'b0, 3, 1'b0, 0, "R6");
        // R2: shared LRU with hits reordering
        access(1'b0, 3, 1'b0, 0, "R2");
        access(1'b1, 3, 1'b1, 1, "R2");
        access(1'b0, 3, 1'b0, 0, "R2");
        access(1'b1, 3, 1'b0, 0, "R2");
        access(1'b0, 3, 1'b1, 3, "R13");
        access(1'b0, 9, 1'b0, 0, "R13");

        // R3: 2+2 split
        set_mode(2);
        for (int i = 0; i < 3; i++) access(1'b1, 7, 1'b0, 0, "R3");
        for (int i = 0; i < 3; i++) access(1'b0, 7, 1'b0, 0, "R3");
        access(1'b1, 7, 1'b1, 1, "R3");
        access(1'b1, 7, 1'b0, 0, "R3");

        // R12 and R4: mode change restores home order, 3+1 split
        set_mode(3);
        access(1'b1, 7, 1'b0, 0, "R12");
        access(1'b0, 7, 1'b0, 0, "R4");
        for (int i = 0; i < 4; i++) access(1'b1, 11, 1'b0, 0, "R4");
        access(1'b0, 11, 1'b0, 0, "R4");
        access(1'b0, 11, 1'b0, 0, "R4");

        // R5: reserved modes behave as shared
        set_mode(5);
        for (int i = 0; i < 5; i++) access(i[0], 12, 1'b0, 0, "R5");
        set_mode(1);
        for (int i = 0; i < 5; i++) access(1'b1, 13, 1'b0, 0, "R5");
        access(1'b0, 13, 1'b0, 0, "R12");

        // R7: locks
        set_mode(0);
        lock_i = 4'b0111;
        access(1'b0, 3, 1'b0, 0, "R7");
        lock_i = 4'b1111;
        access(1'b1, 3, 1'b0, 0, "R7");
        lock_i = 4'b0000;
        set_mode(3);
        lock_i = 4'b1000;
        access(1'b0, 7, 1'b0, 0, "R7");
        lock_i = 4'b0000;

        // R10: allocation enables
        icache_en_i = 1'b0;
        access(1'b1, 14, 1'b0, 0, "R10");
        icache_en_i = 1'b1;
        dcache_en_i = 1'b0;
        access(1'b0, 14, 1'b0, 0, "R10");
        dcache_en_i = 1'b1;
        access(1'b1, 14, 1'b0, 0, "R10");
        access(1'b0, 14, 1'b0, 0, "R10");

        // R8: invalidation of one way across all sets
        set_mode(0);
        for (int i = 0; i < 4; i++) access(1'b0, 4, 1'b0, 0, "R8");
        inval(4'b0010, "R8");
        access(1'b0, 4, 1'b0, 0, "R8");
        access(1'b0, 3, 1'b0, 0, "R8");

        // R9: invalidation overrides lock
        lock_i = 4'b0100;
        inval(4'b0100, "R9");
        lock_i = 4'b0000;
        access(1'b1, 4, 1'b0, 0, "R9");

        // R11: buffer flush strobe leaves ways alone
        @(negedge clk); buf_inv_i = 1'b1;
        @(posedge clk); #1;
        chk(buf_clr_o == 1'b1, "R11", "buf_clr_o pulse", buf_clr_o, 1);
        chk(way_clr_o == 4'h0, "R11", "way_clr_o during flush", way_clr_o, 0);
        @(negedge clk); buf_inv_i = 1'b0;
        @(posedge clk); #1;
        chk(buf_clr_o == 1'b0, "R11", "buf_clr_o end", buf_clr_o, 0);
        access(1'b0, 4, 1'b0, 0, "R11");
        access(1'b0, 3, 1'b0, 0, "R11");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R13", "pending expectations", exp_q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule